// File: doc/BRIEF.md
# Escaped Word-Stream Frame Extractor

This block sits behind a switch CPU extraction queue and turns its stream of 32-bit words back into frames, one at a time. Every frame opens with a fixed-length internal header, after which payload words arrive interleaved with in-band control words. Those control words mark the end of the frame, a pruned frame, an aborted frame, an escaped literal, or a filler word that carries nothing. The block removes the header from the payload. From the header it takes the ingress port number and a 32-bit timestamp. It forwards payload as a word-wide byte stream with a keep mask, a last flag and a drop flag. After each frame it issues a one-cycle summary giving the length, port, timestamp and whether the frame must be discarded.

The byte count of the final data word is only known from the end word that follows it. For that reason the block holds back one data word before forwarding it. Upstream words are taken only when the single output register can accept a beat, so a stalled consumer stalls the queue directly. An optional byte-order reversal is applied to every incoming word before anything else looks at it.

Top module: `xtr_frame_extractor`

## Requirements
- R1: When `swap_en` is high, every incoming word (header, control and payload) is byte-reversed before classification and before forwarding. Throughout, byte 0 of a word is bits [31:24].
- R2: The first `HDR_WORDS` (default 9) words of each frame are header and never appear on the stream, even when they look like control words. The reported timestamp is {h0[15:0], h1[31:16]} and the reported port is h7[20:14], where hN is header word N.
- R3: Payload words leave in arrival order, one beat each. Every beat without `out_last` has `out_keep` = 4'b1111, and keep bit 3 qualifies bits [31:24].
- R4: End word 0x80000000+n (n = 0..3) closes the frame. The closing beat carries the preceding payload word with `out_last` = 1 and keep 1111, 1110, 1100 or 1000 for n = 0, 1, 2, 3. If no payload word is pending, the closing beat has data 0 and keep 0000.
- R5: After the escape word 0x80000006, the next word is payload, even when its value is a control code.
- R6: The filler word 0x80000007 is dropped without producing a beat and without changing frame state.
- R7: After the prune word 0x80000004, the next word (whatever its value) is payload and becomes the closing beat, with keep 1111, `out_last` = 1 and `out_drop` = 1.
- R8: The abort word 0x80000005 ends the frame at once. The closing beat is the pending payload word with keep 1111, or data 0 with keep 0000 if none is pending. It is marked `out_last` = 1 and `out_drop` = 1.
- R9: One cycle after the frame's final word is accepted, `done_valid` pulses for one cycle. `done_len` is then the payload byte count minus 4 (floored at 0): whole words count 4 bytes, and an end word removes n bytes. `done_drop` is 1 for a prune, an abort or an out-of-range port.
- R10: If the header port is NUM_PORTS (default 65) or larger, the frame produces no beats, but a summary with `done_drop` = 1 is still issued.
- R11: `in_ready` is low exactly while a beat is held unaccepted (`out_valid` high and `out_ready` low). A held beat keeps its data, keep, last and drop unchanged until it is taken.
- R12: After reset `out_valid` and `done_valid` are low, `in_ready` is high, and the next word is treated as header word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| swap_en | input | 1 | Reverse the byte order of each incoming word |
| in_valid | input | 1 | Queue word present |
| in_ready | output | 1 | Queue word accepted this cycle when valid |
| in_word | input | 32 | Queue word |
| out_valid | output | 1 | Stream beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32 | Beat data, byte 0 in bits [31:24] |
| out_keep | output | 4 | Valid bytes, bit 3 for bits [31:24] |
| out_last | output | 1 | Final beat of the frame |
| out_drop | output | 1 | Frame ended by prune or abort (only with last) |
| done_valid | output | 1 | One-cycle frame summary strobe |
| done_len | output | LEN_W | Frame length without the 4-byte check sequence |
| done_port | output | 7 | Ingress port from the header |
| done_stamp | output | 32 | Timestamp from the header |
| done_drop | output | 1 | Frame must be discarded |

## Verification
The hardest case to reach from the ports is a closing beat that has to be built while the previous beat is still stalled. In that case the pending word, the end word and consumer backpressure all meet in the same few cycles. The bench reaches it by running a long frame while `out_ready` follows a fixed irregular stall pattern. It also watches the `in_ready` relation on every cycle. Separate frames put control-looking values inside the header, behind escape and prune words, and in a frame from an out-of-range port. This shows that classification depends on frame position and not on word value alone.

// File: rtl/xtr_pkg.sv
// Shared encodings for the escaped word-stream frame extractor.
package xtr_pkg;

    // Classification of one normalised queue word.
    typedef enum logic [2:0] {
        WK_DATA,
        WK_END,
        WK_PRUNE,
        WK_ABORT,
        WK_ESC,
        WK_IDLE
    } wkind_e;

    // Frame parser position.
    typedef enum logic [1:0] {
        FS_HDR,
        FS_BODY,
        FS_LIT,
        FS_TAIL
    } fstate_e;

    // Operation requested from the beat stage.
    typedef enum logic [2:0] {
        BOP_NONE,
        BOP_PUSH,
        BOP_END,
        BOP_SPILL,
        BOP_TAIL
    } bop_e;

    // Upper 29 bits shared by all eight control words.
    localparam logic [28:0] CODE_PREFIX = 29'h1000_0000;

    // Keep mask for a closing word that is short by `short_n` bytes.
    function automatic logic [3:0] keep_for_short(input logic [1:0] short_n);
        case (short_n)
            2'd0:    return 4'b1111;
            2'd1:    return 4'b1110;
            2'd2:    return 4'b1100;
            default: return 4'b1000;
        endcase
    endfunction

endpackage

// File: rtl/xtr_word_norm.sv
// Word normaliser: optionally reverses byte order, then classifies the word.
// Assumes control words differ from each other only in the low three bits.
module xtr_word_norm
    import xtr_pkg::*;
(
    input  logic        swap_en,
    input  logic [31:0] raw_word,
    output logic [31:0] norm_word,
    output wkind_e      kind,
    output logic [1:0]  short_n
);

    logic [31:0] swapped;

    // Byte lane reversal, one lane per generate iteration.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign swapped[8*g +: 8] = raw_word[8*(3-g) +: 8];
    end

    assign norm_word = swap_en ? swapped : raw_word;
    assign short_n   = norm_word[1:0];

    // Decode the control word class from the low bits.
    always_comb begin
        kind = WK_DATA;
        if (norm_word[31:3] == CODE_PREFIX) begin
            case (norm_word[2:0])
                3'd4:    kind = WK_PRUNE;
                3'd5:    kind = WK_ABORT;
                3'd6:    kind = WK_ESC;
                3'd7:    kind = WK_IDLE;
                default: kind = WK_END;
            endcase
        end
    end

endmodule

// File: rtl/xtr_hdr_store.sv
// Header store: keeps the header words of the current frame and extracts
// the ingress port and timestamp. The word being written is bypassed so
// both fields are valid in the cycle the final header word arrives.
// Assumes HDR_WORDS >= 8.
module xtr_hdr_store #(
    parameter int HDR_WORDS = 9,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_word,
    output logic [6:0]       src_port,
    output logic [31:0]      stamp
);

    localparam int STAMP_HI_IDX = 0;
    localparam int STAMP_LO_IDX = 1;
    localparam int PORT_IDX     = 7;

    logic [31:0] hdr_q [HDR_WORDS];
    logic [31:0] view  [HDR_WORDS];

    // Storage of header words at their frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_WORDS; i++) hdr_q[i] <= '0;
        end else if (wr_en) begin
            hdr_q[wr_idx] <= wr_word;
        end
    end

    // Current-cycle view with write bypass.
    for (genvar i = 0; i < HDR_WORDS; i++) begin : g_view
        assign view[i] = (wr_en && wr_idx == IDX_W'(i)) ? wr_word : hdr_q[i];
    end

    assign stamp    = {view[STAMP_HI_IDX][15:0], view[STAMP_LO_IDX][31:16]};
    assign src_port = view[PORT_IDX][20:14];

endmodule

// File: rtl/xtr_beat_stage.sv
// Beat stage: one pending payload word plus the output register.
// Assumes a non-NONE op is only issued when slot_free is high.
module xtr_beat_stage
    import xtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bop_e        op,
    input  logic [31:0] word,
    input  logic [3:0]  end_keep,
    input  logic        end_drop,
    input  logic        out_ready,
    output logic        slot_free,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [3:0]  out_keep,
    output logic        out_last,
    output logic        out_drop
);

    logic        hold_v;
    logic [31:0] hold_d;
    logic        ld_en, ld_last, ld_drop;
    logic [31:0] ld_data;
    logic [3:0]  ld_keep;
    logic        hold_v_d;
    logic [31:0] hold_d_d;

    assign slot_free = !out_valid || out_ready;

    // Select what enters the output register and the pending slot.
    always_comb begin
        ld_en    = 1'b0;
        ld_data  = hold_d;
        ld_keep  = 4'b1111;
        ld_last  = 1'b0;
        ld_drop  = 1'b0;
        hold_v_d = hold_v;
        hold_d_d = hold_d;
        case (op)
            BOP_PUSH: begin
                ld_en    = hold_v;
                hold_v_d = 1'b1;
                hold_d_d = word;
            end
            BOP_END: begin
                ld_en    = 1'b1;
                ld_data  = hold_v ? hold_d : '0;
                ld_keep  = hold_v ? end_keep : 4'b0000;
                ld_last  = 1'b1;
                ld_drop  = end_drop;
                hold_v_d = 1'b0;
            end
            BOP_SPILL: begin
                ld_en    = hold_v;
                hold_v_d = 1'b0;
            end
            BOP_TAIL: begin
                ld_en   = 1'b1;
                ld_data = word;
                ld_last = 1'b1;
                ld_drop = 1'b1;
            end
            default: ;
        endcase
    end

    // Output register and pending word update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_keep  <= '0;
            out_last  <= 1'b0;
            out_drop  <= 1'b0;
            hold_v    <= 1'b0;
            hold_d    <= '0;
        end else begin
            hold_v <= hold_v_d;
            hold_d <= hold_d_d;
            if (ld_en) begin
                out_valid <= 1'b1;
                out_data  <= ld_data;
                out_keep  <= ld_keep;
                out_last  <= ld_last;
                out_drop  <= ld_drop;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xtr_frame_extractor.sv
// Escaped word-stream frame extractor top: header capture, in-band control
// decoding, byte-stream output and per-frame summary.
// Assumes HDR_WORDS >= 8 and that the queue delivers whole frames in order.
module xtr_frame_extractor
    import xtr_pkg::*;
#(
    parameter int HDR_WORDS = 9,
    parameter int NUM_PORTS = 65,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic [3:0]       out_keep,
    output logic             out_last,
    output logic             out_drop,
    output logic             done_valid,
    output logic [LEN_W-1:0] done_len,
    output logic [6:0]       done_port,
    output logic [31:0]      done_stamp,
    output logic             done_drop
);

    localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_WORDS - 1);
    localparam logic [LEN_W-1:0] WORD_B   = LEN_W'(4);

    fstate_e          state_q, state_d;
    logic [IDX_W-1:0] hcnt_q, hcnt_d;
    logic [LEN_W-1:0] bytes_q, bytes_d, end_total;
    logic             drop_q;
    logic             accept, slot_free, hdr_wr, hdr_done;
    logic             end_evt, end_disc;
    logic [3:0]       end_keep;
    bop_e             op, op_eff;
    logic [31:0]      nword;
    wkind_e           kind;
    logic [1:0]       short_n;
    logic [6:0]       hdr_port;
    logic [31:0]      hdr_stamp;

    xtr_word_norm u_norm (
        .swap_en   (swap_en),
        .raw_word  (in_word),
        .norm_word (nword),
        .kind      (kind),
        .short_n   (short_n)
    );

    xtr_hdr_store #(.HDR_WORDS(HDR_WORDS), .IDX_W(IDX_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hdr_wr),
        .wr_idx   (hcnt_q),
        .wr_word  (nword),
        .src_port (hdr_port),
        .stamp    (hdr_stamp)
    );

    xtr_beat_stage u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_eff),
        .word      (nword),
        .end_keep  (end_keep),
        .end_drop  (end_disc),
        .out_ready (out_ready),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_keep  (out_keep),
        .out_last  (out_last),
        .out_drop  (out_drop)
    );

    assign in_ready = slot_free;
    assign accept   = in_valid && in_ready;
    assign op_eff   = drop_q ? BOP_NONE : op;

    // Frame position sequencing and byte accounting per accepted word.
    always_comb begin
        state_d   = state_q;
        hcnt_d    = hcnt_q;
        bytes_d   = bytes_q;
        end_total = bytes_q;
        op        = BOP_NONE;
        end_evt   = 1'b0;
        end_disc  = 1'b0;
        end_keep  = 4'b1111;
        hdr_wr    = 1'b0;
        hdr_done  = 1'b0;
        if (accept) begin
            case (state_q)
                FS_HDR: begin
                    hdr_wr = 1'b1;
                    if (hcnt_q == HDR_LAST) begin
                        hdr_done = 1'b1;
                        hcnt_d   = '0;
                        bytes_d  = '0;
                        state_d  = FS_BODY;
                    end else begin
                        hcnt_d = hcnt_q + 1'b1;
                    end
                end
                FS_BODY: begin
                    case (kind)
                        WK_DATA: begin
                            op      = BOP_PUSH;
                            bytes_d = bytes_q + WORD_B;
                        end
                        WK_END: begin
                            op        = BOP_END;
                            end_keep  = keep_for_short(short_n);
                            end_total = bytes_q - LEN_W'(short_n);
                            end_evt   = 1'b1;
                            state_d   = FS_HDR;
                        end
                        WK_PRUNE: begin
                            op      = BOP_SPILL;
                            state_d = FS_TAIL;
                        end
                        WK_ABORT: begin
                            op       = BOP_END;
                            end_disc = 1'b1;
                            end_evt  = 1'b1;
                            state_d  = FS_HDR;
                        end
                        WK_ESC:  state_d = FS_LIT;
                        default: ;
                    endcase
                end
                FS_LIT: begin
                    op      = BOP_PUSH;
                    bytes_d = bytes_q + WORD_B;
                    state_d = FS_BODY;
                end
                default: begin
                    op        = BOP_TAIL;
                    end_total = bytes_q + WORD_B;
                    end_evt   = 1'b1;
                    end_disc  = 1'b1;
                    state_d   = FS_HDR;
                end
            endcase
        end
    end

    // Parser state, header index, byte count and port-range verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_HDR;
            hcnt_q  <= '0;
            bytes_q <= '0;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
            bytes_q <= bytes_d;
            if (hdr_done) drop_q <= (32'(hdr_port) >= NUM_PORTS);
        end
    end

    // Frame summary, registered one cycle after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_len   <= '0;
            done_port  <= '0;
            done_stamp <= '0;
            done_drop  <= 1'b0;
        end else begin
            done_valid <= end_evt;
            if (end_evt) begin
                done_len   <= (end_total >= WORD_B) ? end_total - WORD_B : '0;
                done_port  <= hdr_port;
                done_stamp <= hdr_stamp;
                done_drop  <= end_disc || drop_q;
            end
        end
    end

endmodule

// File: rtl/xtr_frame_extractor_chk.sv
// Property checker for the frame extractor ports, attached by bind below.
module xtr_frame_extractor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic [3:0]  out_keep,
    input logic        out_last,
    input logic        out_drop,
    input logic        done_valid
);

    // R11: a stalled beat keeps every field until it is taken.
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
        $stable(out_keep) && $stable(out_last) && $stable(out_drop));

    // R11: no word is taken while a beat is stalled.
    a_r11_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R3: beats before the last one are full.
    a_r3_full_mid_beats: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> out_keep == 4'b1111);

    // R8: the drop mark only rides on a closing beat.
    a_r8_drop_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_drop |-> out_last);

    // R4: an empty beat can only be a closing beat.
    a_r4_empty_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_keep == 4'b0000 |-> out_last);

    // R9: the summary strobe lasts one cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R12: leaving reset, nothing is offered and input is accepted.
    a_r12_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && !done_valid && in_ready);

endmodule

bind xtr_frame_extractor xtr_frame_extractor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_keep   (out_keep),
    .out_last   (out_last),
    .out_drop   (out_drop),
    .done_valid (done_valid)
);

// File: tb/xtr_frame_extractor_bench.sv
// Directed bench for the escaped word-stream frame extractor.
module xtr_frame_extractor_bench;

    localparam int LEN_W = 16;
    localparam logic [31:0] C_END0  = 32'h8000_0000;
    localparam logic [31:0] C_PRUNE = 32'h8000_0004;
    localparam logic [31:0] C_ABORT = 32'h8000_0005;
    localparam logic [31:0] C_ESC   = 32'h8000_0006;
    localparam logic [31:0] C_IDLE  = 32'h8000_0007;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             swap_en = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_word = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [31:0]      out_data;
    logic [3:0]       out_keep;
    logic             out_last;
    logic             out_drop;
    logic             done_valid;
    logic [LEN_W-1:0] done_len;
    logic [6:0]       done_port;
    logic [31:0]      done_stamp;
    logic             done_drop;

    int n_chk = 0;
    int n_bad = 0;
    logic stall_en = 1'b0;
    int stall_cnt = 0;
    int rdy_err = 0;

    logic [37:0] rec_b [64];
    logic [37:0] exp_b [64];
    int rec_n = 0;
    int exp_n = 0;
    logic [55:0] rec_d;
    int done_n = 0;

    xtr_frame_extractor #(.HDR_WORDS(9), .NUM_PORTS(65), .LEN_W(LEN_W)) u_xtr_frame_extractor (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last), .out_drop(out_drop),
        .done_valid(done_valid), .done_len(done_len), .done_port(done_port),
        .done_stamp(done_stamp), .done_drop(done_drop)
    );

    always #5 clk = ~clk;

    // Consumer readiness: steady or a fixed irregular stall pattern.
    always begin
        @(posedge clk);
        #1;
        stall_cnt = stall_cnt + 1;
        out_ready = stall_en ? ((stall_cnt % 3) != 1 && (stall_cnt % 7) != 2) : 1'b1;
    end

    // Output monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && rec_n < 64) begin
                rec_b[rec_n] = {out_data, out_keep, out_last, out_drop};
                rec_n = rec_n + 1;
            end
            if (done_valid) begin
                rec_d = {done_len, done_port, done_stamp, done_drop};
                done_n = done_n + 1;
            end
            if ((out_valid && !out_ready) == in_ready) rdy_err = rdy_err + 1;
        end
    end

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] hdr_word(input int i, input logic [6:0] p, input logic [31:0] ts);
        case (i)
            0:       return {16'hC0DE, ts[31:16]};
            1:       return {ts[15:0], 16'h8000};
            7:       return {11'h7FF, p, 14'h3FFF};
            default: return 32'h8000_0000 | 32'(i);
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        in_word  = swap_en ? bswap(w) : w;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic [6:0] p, input logic [31:0] ts);
        for (int i = 0; i < 9; i++) put(hdr_word(i, p, ts));
    endtask

    task automatic expect_beat(input logic [31:0] d, input logic [3:0] k, input logic l, input logic x);
        exp_b[exp_n] = {d, k, l, x};
        exp_n = exp_n + 1;
    endtask

    // Drain, then compare beats and the frame summary.
    task automatic end_frame(input string req, input logic [LEN_W-1:0] len, input logic [6:0] p,
                             input logic [31:0] ts, input logic x);
        repeat (20) @(posedge clk);
        #2;
        check(req, "beat count", 64'(rec_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < rec_n; i++)
            check(req, $sformatf("beat %0d {data,keep,last,drop}", i), 64'(rec_b[i]), 64'(exp_b[i]));
        check(req, "summary count", 64'(done_n), 64'd1);
        check(req, "summary {len,port,stamp,drop}", 64'(rec_d), 64'({len, p, ts, x}));
        rec_n = 0;
        exp_n = 0;
        done_n = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R12", "out_valid", 64'(out_valid), 64'd0);
        check("R12", "done_valid", 64'(done_valid), 64'd0);
        check("R12", "in_ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        #2;
    endtask

    task automatic t_basic;
        send_hdr(7'd5, 32'h1122_3344);
        put(32'h0102_0304); put(32'h1111_2222); put(32'hAABB_CCDD); put(32'h8000_0002);
        expect_beat(32'h0102_0304, 4'b1111, 1'b0, 1'b0);
        expect_beat(32'h1111_2222, 4'b1111, 1'b0, 1'b0);
        expect_beat(32'hAABB_CCDD, 4'b1100, 1'b1, 1'b0);
        end_frame("R3 R2 R9 basic", 16'd6, 7'd5, 32'h1122_3344, 1'b0);
    endtask

    task automatic t_end_lanes;
        logic [3:0] k;
        for (int n = 0; n < 4; n++) begin
            k = (n == 0) ? 4'b1111 : (n == 1) ? 4'b1110 : (n == 2) ? 4'b1100 : 4'b1000;
            send_hdr(7'(n + 1), 32'h0000_1000 + 32'(n));
            put(32'h2000_0000 + 32'(n)); put(32'h3000_0000 + 32'(n)); put(C_END0 | 32'(n));
            expect_beat(32'h2000_0000 + 32'(n), 4'b1111, 1'b0, 1'b0);
            expect_beat(32'h3000_0000 + 32'(n), k, 1'b1, 1'b0);
            end_frame("R4 end lanes", LEN_W'(4 - n), 7'(n + 1), 32'h0000_1000 + 32'(n), 1'b0);
        end
    endtask

    task automatic t_empty;
        send_hdr(7'd2, 32'h5555_0000);
        put(C_END0);
        expect_beat(32'h0, 4'b0000, 1'b1, 1'b0);
        end_frame("R4 empty frame", 16'd0, 7'd2, 32'h5555_0000, 1'b0);
    endtask

    task automatic t_escape;
        send_hdr(7'd3, 32'hCAFE_0001);
        put(32'h4444_0000); put(C_ESC); put(C_ABORT); put(C_ESC); put(C_ESC); put(C_END0);
        expect_beat(32'h4444_0000, 4'b1111, 1'b0, 1'b0);
        expect_beat(C_ABORT, 4'b1111, 1'b0, 1'b0);
        expect_beat(C_ESC, 4'b1111, 1'b1, 1'b0);
        end_frame("R5 escape", 16'd8, 7'd3, 32'hCAFE_0001, 1'b0);
    endtask

    task automatic t_idle;
        send_hdr(7'd4, 32'h0BAD_F00D);
        put(C_IDLE); put(32'h6060_6060); put(C_IDLE); put(C_IDLE);
        put(32'h7070_7070); put(C_IDLE); put(32'h8000_0001);
        expect_beat(32'h6060_6060, 4'b1111, 1'b0, 1'b0);
        expect_beat(32'h7070_7070, 4'b1110, 1'b1, 1'b0);
        end_frame("R6 filler", 16'd3, 7'd4, 32'h0BAD_F00D, 1'b0);
    endtask

    task automatic t_prune;
        send_hdr(7'd6, 32'h0000_0077);
        put(32'h9191_0000); put(32'h9292_0000); put(C_PRUNE); put(C_END0);
        expect_beat(32'h9191_0000, 4'b1111, 1'b0, 1'b0);
        expect_beat(32'h9292_0000, 4'b1111, 1'b0, 1'b0);
        expect_beat(C_END0, 4'b1111, 1'b1, 1'b1);
        end_frame("R7 R9 prune", 16'd8, 7'd6, 32'h0000_0077, 1'b1);
    endtask

    task automatic t_abort;
        send_hdr(7'd7, 32'h1234_5678);
        put(32'hABAB_0000); put(C_ABORT);
        expect_beat(32'hABAB_0000, 4'b1111, 1'b1, 1'b1);
        end_frame("R8 abort with word", 16'd0, 7'd7, 32'h1234_5678, 1'b1);
        send_hdr(7'd8, 32'h8765_4321);
        put(C_ABORT);
        expect_beat(32'h0, 4'b0000, 1'b1, 1'b1);
        end_frame("R8 abort empty", 16'd0, 7'd8, 32'h8765_4321, 1'b1);
    endtask

    task automatic t_swap;
        swap_en = 1'b1;
        send_hdr(7'd9, 32'hDEAD_BEEF);
        put(32'h0A0B_0C0D); put(C_IDLE); put(32'h1A1B_1C1D); put(32'h8000_0003);
        expect_beat(32'h0A0B_0C0D, 4'b1111, 1'b0, 1'b0);
        expect_beat(32'h1A1B_1C1D, 4'b1000, 1'b1, 1'b0);
        end_frame("R1 byte swap", 16'd1, 7'd9, 32'hDEAD_BEEF, 1'b0);
        swap_en = 1'b0;
    endtask

    task automatic t_ports;
        send_hdr(7'd64, 32'h0000_0040);
        put(32'hEEEE_0000); put(C_END0);
        expect_beat(32'hEEEE_0000, 4'b1111, 1'b1, 1'b0);
        end_frame("R10 highest valid port", 16'd0, 7'd64, 32'h0000_0040, 1'b0);
        send_hdr(7'd65, 32'h0000_0041);
        put(32'hDDDD_0000); put(32'hDDDD_0001); put(C_ESC); put(C_END0); put(C_END0);
        end_frame("R10 out-of-range port", 16'd8, 7'd65, 32'h0000_0041, 1'b1);
    endtask

    task automatic t_backpressure;
        rdy_err = 0;
        stall_en = 1'b1;
        send_hdr(7'd10, 32'h0F0F_0F0F);
        for (int i = 0; i < 12; i++) begin
            put(32'hB000_0000 + 32'(i));
            expect_beat(32'hB000_0000 + 32'(i), 4'b1111, 1'b0, 1'b0);
        end
        put(32'h8000_0002);
        exp_b[11] = {32'hB000_000B, 4'b1100, 1'b1, 1'b0};
        end_frame("R11 backpressure", 16'd42, 7'd10, 32'h0F0F_0F0F, 1'b0);
        stall_en = 1'b0;
        check("R11", "in_ready rule violations", 64'(rdy_err), 64'd0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_end_lanes();
        t_empty();
        t_escape();
        t_idle();
        t_prune();
        t_abort();
        t_swap();
        t_ports();
        t_backpressure();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule